// File: doc/BRIEF.md
# Runtime-Switch Fetch Redirect Unit

This unit sits between the decode and fetch stages of a small in-order core. When decode presents a dedicated "enter runtime" opcode, the unit checkpoints the return point of the user program. It steers instruction fetch away from application memory and toward a separate firmware store that holds the language runtime. It also flushes the younger instructions already in flight. The firmware entry point is formed from a programmable base register plus an index carried in the opcode's immediate field.

Before entering, the application places pointers to its data structures in argument registers. The unit snapshots those registers at the moment of the switch. It holds the snapshot unchanged for the runtime to read, even while the live register values move on. A matching "leave runtime" opcode restores the checkpointed PC and puts fetch back on application memory.

A second enter opcode seen while the runtime is already running is refused. It raises a sticky error flag and changes nothing else.

Top module: `rsw_unit`

## Requirements
- R1: After reset, fetchFromFw, redirectValid, flushYoung, ctxSave, ctxRestore and nestErr are 0, redirectPc is 0 and argOut is 0.
- R2: An enter opcode (decOpcode == OP_SWITCH, default 7'h0B) accepted in application mode gives, one cycle later, a one-cycle pulse on redirectValid, flushYoung and ctxSave, and fetchFromFw goes to 1 and stays 1.
- R3: On entry, redirectPc equals the base register plus decImm shifted left by ENTRY_SHIFT (default 4). The base register is the value held before the current edge: a base write in the same cycle as an enter only affects later entries.
- R4: argOut captures argIn at an accepted entry and then keeps that value while argIn changes, until the next accepted entry.
- R5: A leave opcode (decOpcode == OP_RETURN, default 7'h2B) accepted in runtime mode gives, one cycle later, a one-cycle pulse on redirectValid, flushYoung and ctxRestore, with redirectPc equal to the enter opcode's decPc plus PC_STEP (default 4), and fetchFromFw returns to 0.
- R6: An enter opcode accepted in runtime mode sets nestErr from the next cycle. It produces no redirect, flush or save, and leaves redirectPc and argOut unchanged. nestErr stays 1 until a leave opcode is taken, which clears it in the same cycle as its redirect.
- R7: A leave opcode in application mode has no effect: no strobe fires and redirectPc keeps its value.
- R8: An opcode presented in a cycle where flushYoung is 1 is treated as a flushed younger instruction and ignored.
- R9: With decValid at 0, no opcode value has any effect.
- R10: ctxSave and ctxRestore never assert in the same cycle, and redirectValid is always accompanied by flushYoung.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| decValid | input | 1 | Decode holds a valid instruction |
| decOpcode | input | OP_W | Opcode of the decoded instruction |
| decImm | input | IDX_W | Runtime entry index from the immediate field |
| decPc | input | PC_W | PC of the decoded instruction |
| baseWrEn | input | 1 | Write strobe for the firmware base register |
| baseWrData | input | PC_W | New firmware base address |
| argIn | input | NARGS*DATA_W | Live argument registers, flattened |
| redirectValid | output | 1 | Fetch must restart at redirectPc |
| redirectPc | output | PC_W | Redirect target |
| fetchFromFw | output | 1 | 1 selects the firmware store, 0 application memory |
| flushYoung | output | 1 | Kill instructions younger than the switch point |
| ctxSave | output | 1 | Checkpoint the user context |
| ctxRestore | output | 1 | Restore the checkpointed user context |
| nestErr | output | 1 | Sticky flag for a refused nested entry |
| argOut | output | NARGS*DATA_W | Argument snapshot taken at entry |

## Verification
Two events can collide in one cycle. The first is a base register write together with an enter opcode; the bench drives both on the same edge and expects the redirect target to use the old base, with the new base showing up only on the following entry. The second is an opcode arriving in the very cycle the flush strobe is high; the bench presents a leave opcode right behind an entry and expects fetch to stay on firmware with no second redirect. Every other expected target and snapshot comes from a sweep over all entry indices and several base values, with the arithmetic done in the bench.

// File: rtl/rsw_pkg.sv
package rsw_pkg;
  // Decisions made by the control, consumed by the datapath
  typedef struct packed {
    logic enter;   // accepted entry into the runtime
    logic leave;   // accepted return to the application
    logic nest;    // refused nested entry
  } rswStrobe_t;

  typedef enum logic {
    MODE_APP = 1'b0,
    MODE_FW  = 1'b1
  } rswMode_t;
endpackage

// File: rtl/rsw_ctrl.sv
module rsw_ctrl #(
  parameter int OP_W = 7,
  parameter logic [OP_W-1:0] OP_SWITCH = 7'h0B,
  parameter logic [OP_W-1:0] OP_RETURN = 7'h2B
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                decValid,
  input  logic [OP_W-1:0]     decOpcode,
  output rsw_pkg::rswStrobe_t strobe,
  output logic                redirectValid,
  output logic                flushYoung,
  output logic                ctxSave,
  output logic                ctxRestore,
  output logic                fetchFromFw,
  output logic                nestErr
);
  import rsw_pkg::*;

  rswMode_t mode;
  logic     live;
  logic     isSwitch;
  logic     isReturn;

  // An instruction seen while the flush is active is a younger one: drop it
  assign live     = decValid && !flushYoung;
  assign isSwitch = live && (decOpcode == OP_SWITCH);
  assign isReturn = live && (decOpcode == OP_RETURN);

  always_comb begin
    strobe.enter = isSwitch && (mode == MODE_APP);
    strobe.nest  = isSwitch && (mode == MODE_FW);
    strobe.leave = isReturn && (mode == MODE_FW);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode          <= MODE_APP;
      redirectValid <= 1'b0;
      flushYoung    <= 1'b0;
      ctxSave       <= 1'b0;
      ctxRestore    <= 1'b0;
      nestErr       <= 1'b0;
    end else begin
      redirectValid <= strobe.enter || strobe.leave;
      flushYoung    <= strobe.enter || strobe.leave;
      ctxSave       <= strobe.enter;
      ctxRestore    <= strobe.leave;
      if (strobe.enter)      mode <= MODE_FW;
      else if (strobe.leave) mode <= MODE_APP;
      if (strobe.leave)      nestErr <= 1'b0;
      else if (strobe.nest)  nestErr <= 1'b1;
    end
  end

  assign fetchFromFw = (mode == MODE_FW);
endmodule

// File: rtl/rsw_dpath.sv
module rsw_dpath #(
  parameter int PC_W = 32,
  parameter int IDX_W = 4,
  parameter int DATA_W = 32,
  parameter int NARGS = 4,
  parameter int ENTRY_SHIFT = 4,
  parameter int PC_STEP = 4,
  parameter logic [PC_W-1:0] FW_BASE_RST = 32'h0001_0000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  rsw_pkg::rswStrobe_t     strobe,
  input  logic [PC_W-1:0]         decPc,
  input  logic [IDX_W-1:0]        decImm,
  input  logic                    baseWrEn,
  input  logic [PC_W-1:0]         baseWrData,
  input  logic [NARGS*DATA_W-1:0] argIn,
  output logic [PC_W-1:0]         redirectPc,
  output logic [NARGS*DATA_W-1:0] argOut
);
  logic [PC_W-1:0] baseQ;
  logic [PC_W-1:0] savedPc;
  logic [PC_W-1:0] entryOff;
  logic [PC_W-1:0] entryPc;

  assign entryOff = PC_W'(decImm) << ENTRY_SHIFT;
  assign entryPc  = baseQ + entryOff;

  always_ff @(posedge clk) begin
    if (!rst_n)        baseQ <= FW_BASE_RST;
    else if (baseWrEn) baseQ <= baseWrData;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      savedPc    <= '0;
      redirectPc <= '0;
    end else if (strobe.enter) begin
      savedPc    <= decPc + PC_W'(PC_STEP);
      redirectPc <= entryPc;
    end else if (strobe.leave) begin
      redirectPc <= savedPc;
    end
  end

  for (genvar g = 0; g < NARGS; g++) begin : g_arg
    always_ff @(posedge clk) begin
      if (!rst_n)
        argOut[g*DATA_W +: DATA_W] <= '0;
      else if (strobe.enter)
        argOut[g*DATA_W +: DATA_W] <= argIn[g*DATA_W +: DATA_W];
    end
  end
endmodule

// File: rtl/rsw_unit.sv
module rsw_unit #(
  parameter int PC_W = 32,
  parameter int IDX_W = 4,
  parameter int OP_W = 7,
  parameter int DATA_W = 32,
  parameter int NARGS = 4,
  parameter int ENTRY_SHIFT = 4,
  parameter int PC_STEP = 4,
  parameter logic [OP_W-1:0] OP_SWITCH = 7'h0B,
  parameter logic [OP_W-1:0] OP_RETURN = 7'h2B,
  parameter logic [PC_W-1:0] FW_BASE_RST = 32'h0001_0000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    decValid,
  input  logic [OP_W-1:0]         decOpcode,
  input  logic [IDX_W-1:0]        decImm,
  input  logic [PC_W-1:0]         decPc,
  input  logic                    baseWrEn,
  input  logic [PC_W-1:0]         baseWrData,
  input  logic [NARGS*DATA_W-1:0] argIn,
  output logic                    redirectValid,
  output logic [PC_W-1:0]         redirectPc,
  output logic                    fetchFromFw,
  output logic                    flushYoung,
  output logic                    ctxSave,
  output logic                    ctxRestore,
  output logic                    nestErr,
  output logic [NARGS*DATA_W-1:0] argOut
);
  rsw_pkg::rswStrobe_t strobe;

  rsw_ctrl #(
    .OP_W(OP_W), .OP_SWITCH(OP_SWITCH), .OP_RETURN(OP_RETURN)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .decValid(decValid), .decOpcode(decOpcode),
    .strobe(strobe), .redirectValid(redirectValid), .flushYoung(flushYoung),
    .ctxSave(ctxSave), .ctxRestore(ctxRestore), .fetchFromFw(fetchFromFw),
    .nestErr(nestErr)
  );

  rsw_dpath #(
    .PC_W(PC_W), .IDX_W(IDX_W), .DATA_W(DATA_W), .NARGS(NARGS),
    .ENTRY_SHIFT(ENTRY_SHIFT), .PC_STEP(PC_STEP), .FW_BASE_RST(FW_BASE_RST)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .decPc(decPc), .decImm(decImm),
    .baseWrEn(baseWrEn), .baseWrData(baseWrData), .argIn(argIn),
    .redirectPc(redirectPc), .argOut(argOut)
  );
endmodule

// File: rtl/rsw_checker.sv
module rsw_checker #(
  parameter int OP_W = 7,
  parameter int ARG_W = 128,
  parameter logic [OP_W-1:0] OP_SWITCH = 7'h0B,
  parameter logic [OP_W-1:0] OP_RETURN = 7'h2B
) (
  input logic             clk,
  input logic             rst_n,
  input logic             decValid,
  input logic [OP_W-1:0]  decOpcode,
  input logic             redirectValid,
  input logic             flushYoung,
  input logic             ctxSave,
  input logic             ctxRestore,
  input logic             fetchFromFw,
  input logic             nestErr,
  input logic [ARG_W-1:0] argOut
);
  logic takeSw;
  logic takeRet;
  assign takeSw  = decValid && !flushYoung && (decOpcode == OP_SWITCH);
  assign takeRet = decValid && !flushYoung && (decOpcode == OP_RETURN);

  assert_enter_R2: assert property (@(posedge clk) disable iff (!rst_n)
    takeSw && !fetchFromFw |=> fetchFromFw && ctxSave && redirectValid);

  assert_save_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ctxSave |=> !ctxSave);

  assert_leave_R5: assert property (@(posedge clk) disable iff (!rst_n)
    takeRet && fetchFromFw |=> !fetchFromFw && ctxRestore && !nestErr);

  assert_nest_R6: assert property (@(posedge clk) disable iff (!rst_n)
    takeSw && fetchFromFw |=> nestErr && !redirectValid && !ctxSave && $stable(argOut));

  assert_app_return_R7: assert property (@(posedge clk) disable iff (!rst_n)
    takeRet && !fetchFromFw |=> !redirectValid && !ctxRestore);

  assert_flush_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flushYoung |=> $stable(fetchFromFw) && !redirectValid);

  assert_save_restore_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctxSave && ctxRestore));

  assert_redirect_flush_R10: assert property (@(posedge clk) disable iff (!rst_n)
    redirectValid |-> flushYoung);
endmodule

bind rsw_unit rsw_checker #(
  .OP_W(OP_W), .ARG_W(NARGS*DATA_W), .OP_SWITCH(OP_SWITCH), .OP_RETURN(OP_RETURN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .decValid(decValid), .decOpcode(decOpcode),
  .redirectValid(redirectValid), .flushYoung(flushYoung), .ctxSave(ctxSave),
  .ctxRestore(ctxRestore), .fetchFromFw(fetchFromFw), .nestErr(nestErr),
  .argOut(argOut)
);

// File: tb/sim_rsw_unit.sv
`timescale 1ns/1ps
module sim_rsw_unit;
  localparam int PC_W = 32;
  localparam int IDX_W = 4;
  localparam int OP_W = 7;
  localparam int DATA_W = 32;
  localparam int NARGS = 4;
  localparam int AW = NARGS*DATA_W;
  localparam logic [OP_W-1:0] SW  = 7'h0B;
  localparam logic [OP_W-1:0] RET = 7'h2B;
  localparam logic [PC_W-1:0] BASE_RST = 32'h0001_0000;

  logic clk = 0;
  logic rst_n = 0;
  logic decValid = 0;
  logic [OP_W-1:0] decOpcode = '0;
  logic [IDX_W-1:0] decImm = '0;
  logic [PC_W-1:0] decPc = '0;
  logic baseWrEn = 0;
  logic [PC_W-1:0] baseWrData = '0;
  logic [AW-1:0] argIn = '0;
  logic redirectValid, fetchFromFw, flushYoung, ctxSave, ctxRestore, nestErr;
  logic [PC_W-1:0] redirectPc;
  logic [AW-1:0] argOut;

  int vectors = 0;
  int miscompares = 0;

  always #5 clk = ~clk;

  rsw_unit u0 (
    .clk(clk), .rst_n(rst_n), .decValid(decValid), .decOpcode(decOpcode),
    .decImm(decImm), .decPc(decPc), .baseWrEn(baseWrEn), .baseWrData(baseWrData),
    .argIn(argIn), .redirectValid(redirectValid), .redirectPc(redirectPc),
    .fetchFromFw(fetchFromFw), .flushYoung(flushYoung), .ctxSave(ctxSave),
    .ctxRestore(ctxRestore), .nestErr(nestErr), .argOut(argOut)
  );

  task automatic chk(string req, logic [AW-1:0] act, logic [AW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Present one decoded op for one cycle; returns at the negedge after the edge that took it
  task automatic present(logic [OP_W-1:0] op, logic [IDX_W-1:0] imm, logic [PC_W-1:0] pc);
    @(negedge clk);
    decValid = 1; decOpcode = op; decImm = imm; decPc = pc;
    @(negedge clk);
    decValid = 0; decOpcode = '0;
  endtask

  task automatic writeBase(logic [PC_W-1:0] b);
    @(negedge clk);
    baseWrEn = 1; baseWrData = b;
    @(negedge clk);
    baseWrEn = 0;
  endtask

  function automatic logic [AW-1:0] mkArgs(int seed);
    logic [AW-1:0] v;
    for (int k = 0; k < NARGS; k++)
      v[k*DATA_W +: DATA_W] = DATA_W'(32'h1000_0000 * (k+1) + seed * 32'h0101 + k);
    return v;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [PC_W-1:0] base;
    logic [PC_W-1:0] pc;
    logic [AW-1:0] snap;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 fetchFromFw", AW'(fetchFromFw), 0);
    chk("R1 redirectValid", AW'(redirectValid), 0);
    chk("R1 flushYoung", AW'(flushYoung), 0);
    chk("R1 ctxSave", AW'(ctxSave), 0);
    chk("R1 ctxRestore", AW'(ctxRestore), 0);
    chk("R1 nestErr", AW'(nestErr), 0);
    chk("R1 redirectPc", AW'(redirectPc), 0);
    chk("R1 argOut", argOut, 0);

    // R9: switch opcode with decValid low
    @(negedge clk);
    decValid = 0; decOpcode = SW; decImm = 4'h5; decPc = 32'h200;
    @(negedge clk);
    decOpcode = '0;
    chk("R9 fetchFromFw", AW'(fetchFromFw), 0);
    chk("R9 redirectValid", AW'(redirectValid), 0);
    chk("R9 ctxSave", AW'(ctxSave), 0);

    // R7: return in application mode
    present(RET, 0, 32'h300);
    chk("R7 redirectValid", AW'(redirectValid), 0);
    chk("R7 ctxRestore", AW'(ctxRestore), 0);
    chk("R7 redirectPc", AW'(redirectPc), 0);
    chk("R7 fetchFromFw", AW'(fetchFromFw), 0);

    // R3: reset base used by first entry
    present(SW, 4'h2, 32'h400);
    chk("R3 reset base target", AW'(redirectPc), AW'(BASE_RST + 32'h20));
    present(RET, 0, 32'h0);
    chk("R5 return target", AW'(redirectPc), AW'(32'h404));

    // Sweep: bases x all entry indices
    for (int b = 0; b < 4; b++) begin
      base = 32'h0040_0000 + PC_W'(b) * 32'h0003_1000;
      writeBase(base);
      for (int i = 0; i < 16; i++) begin
        pc = 32'h0000_1000 + PC_W'(i) * 8 + PC_W'(b) * 32'h100;
        argIn = mkArgs(b*16 + i);
        snap = argIn;
        present(SW, IDX_W'(i), pc);
        chk("R2 redirectValid", AW'(redirectValid), 1);
        chk("R2 flushYoung", AW'(flushYoung), 1);
        chk("R2 ctxSave", AW'(ctxSave), 1);
        chk("R10 ctxRestore low on entry", AW'(ctxRestore), 0);
        chk("R2 fetchFromFw", AW'(fetchFromFw), 1);
        chk("R3 entry target", AW'(redirectPc), AW'(base + PC_W'(i) * 16));
        chk("R4 snapshot", argOut, snap);
        argIn = ~argIn;
        @(negedge clk);
        chk("R2 pulse ends", AW'({redirectValid, flushYoung, ctxSave}), 0);
        chk("R2 stays in firmware", AW'(fetchFromFw), 1);
        chk("R4 snapshot held", argOut, snap);
        present(RET, 0, 32'h0);
        chk("R5 redirectValid", AW'(redirectValid), 1);
        chk("R5 ctxRestore", AW'(ctxRestore), 1);
        chk("R10 ctxSave low on leave", AW'(ctxSave), 0);
        chk("R5 target", AW'(redirectPc), AW'(pc + 4));
        chk("R5 fetchFromFw", AW'(fetchFromFw), 0);
        chk("R4 held after leave", argOut, snap);
      end
    end

    // R6: nested entry refused
    base = 32'h0080_0000;
    writeBase(base);
    argIn = mkArgs(99); snap = argIn;
    present(SW, 4'h1, 32'h5000);
    argIn = mkArgs(7);
    @(negedge clk);
    present(SW, 4'h9, 32'h6000);
    chk("R6 nestErr", AW'(nestErr), 1);
    chk("R6 no redirect", AW'(redirectValid), 0);
    chk("R6 no save", AW'(ctxSave), 0);
    chk("R6 target kept", AW'(redirectPc), AW'(base + 32'h10));
    chk("R6 args kept", argOut, snap);
    chk("R6 still firmware", AW'(fetchFromFw), 1);
    @(negedge clk);
    chk("R6 nestErr sticky", AW'(nestErr), 1);
    present(RET, 0, 32'h0);
    chk("R6 nestErr cleared", AW'(nestErr), 0);
    chk("R6 return to first caller", AW'(redirectPc), AW'(32'h5004));

    // R8: opcode in the flush cycle ignored
    present(SW, 4'h3, 32'h7000);
    chk("R8 flush high", AW'(flushYoung), 1);
    decValid = 1; decOpcode = RET;
    @(negedge clk);
    decValid = 0; decOpcode = '0;
    chk("R8 fetchFromFw", AW'(fetchFromFw), 1);
    chk("R8 no redirect", AW'(redirectValid), 0);
    chk("R8 no restore", AW'(ctxRestore), 0);
    present(RET, 0, 32'h0);
    chk("R8 later return", AW'(redirectPc), AW'(32'h7004));

    // R3: base write in the same cycle as an entry
    @(negedge clk);
    baseWrEn = 1; baseWrData = 32'h00C0_0000;
    decValid = 1; decOpcode = SW; decImm = 4'h3; decPc = 32'h8000;
    @(negedge clk);
    baseWrEn = 0; decValid = 0; decOpcode = '0;
    chk("R3 old base on collision", AW'(redirectPc), AW'(base + 32'h30));
    present(RET, 0, 32'h0);
    present(SW, 4'h3, 32'h9000);
    chk("R3 new base afterward", AW'(redirectPc), AW'(32'h00C0_0030));
    present(RET, 0, 32'h0);
    chk("R5 final return", AW'(redirectPc), AW'(32'h9004));

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule